// File: doc/BRIEF.md
# Serial LCD Segment Driver Core

This block is the digital heart of a chainable segment driver for liquid crystal panels. A serial bit stream is clocked into a 38-stage shift register, one bit per falling edge of a serial clock, but only while an active-low select input is asserted. A load input moves the register contents into a display latch. While load stays high the latch follows the register, so the segments track the shifting data. Each segment output is its latched bit combined with the backplane phase. A lit segment runs in antiphase to the backplane, and a dark segment runs in phase with it.

The backplane has two sources. It can follow an external display clock directly. It can also come from an internal eight-bit counter that counts rising edges of the same input, which divides that input by 256. A cascade output repeats a chosen register stage and changes only on the rising serial-clock edge. This lets a second driver that shares the serial clock take the bit safely on its own falling edge. All inputs are brought into one system clock domain through two-flop synchronizers. The system clock must run at least eight times faster than the serial clock.

Top module: `lcdseg_core`

## Requirements
- R1: Each falling serial-clock edge with `sel_n` low shifts the register by one place, taking `ser_dat` into stage 1. After 38 such shifts, the first bit sent sits in stage 38 and appears on `seg[37]`. Stage k drives `seg[k-1]`.
- R2: A falling edge with `sel_n` high leaves the register unchanged. A rising serial-clock edge never shifts the register.
- R3: While `load` is high, the latch copies the register every cycle, so it is transparent during shifting. While `load` is low, the latch holds its value.
- R4: `casc_out` changes only in response to a rising serial-clock edge. A change of `tap_sel` alone does not move it.
- R5: On a rising serial-clock edge, `casc_out` takes the register stage chosen by `tap_sel`: 0 selects stage 30, 1 selects stage 32, 2 selects stage 34, 3 selects stage 38. This happens whatever the level of `sel_n`.
- R6: For every segment, `seg[i]` equals `bp` when latch bit i is 0 and equals the inverse of `bp` when it is 1.
- R7: With `bp_mode` = 0, `bp` follows the level of `disp_clk`, after the input synchronizer.
- R8: With `bp_mode` = 1, `bp` is bit 7 of a counter of `disp_clk` rising edges since reset. It is low for counts 0 to 127 and high for counts 128 to 255, and then it repeats.
- R9: Synchronous reset clears the register, the latch and the divider, and drives `casc_out` low.
- R10: Two instances chained from `casc_out` (tap 38) to `ser_dat` hold 76 serially sent bits in order. The first 38 bits end up in the second device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock: shifts on its falling edge, updates the cascade on its rising edge |
| ser_dat | input | 1 | Serial data input |
| sel_n | input | 1 | Active-low select that gates shifting |
| load | input | 1 | Latch load; transparent while high |
| disp_clk | input | 1 | External display clock or oscillator input |
| bp_mode | input | 1 | 0: backplane follows the input, 1: backplane is the input divided by 256 |
| tap_sel | input | 2 | Cascade tap: 0 selects stage 30, 1 stage 32, 2 stage 34, 3 stage 38 |
| seg | output | 38 | Segment phase outputs |
| bp | output | 1 | Backplane phase |
| casc_out | output | 1 | Cascade serial output |

## Verification
The hardest state to reach is a second device whose input is the first device's cascade output. That input must be valid at the shared falling edge even though it only changed at the rising edge before it. The bench chains two instances and streams 76 random bits through them. It then checks both latches bit by bit. The divided backplane only moves after 128 display-clock edges, so the bench counts its own pulses and samples just before and just after each toggle point.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;
    localparam int STAGES   = 38;
    localparam int DIV_BITS = 8;
    localparam int SYNC_LEN = 2;

    typedef enum logic [1:0] {
        TAP_S30 = 2'd0,
        TAP_S32 = 2'd1,
        TAP_S34 = 2'd2,
        TAP_S38 = 2'd3
    } tap_e;

    typedef enum logic {
        BP_EXTERNAL = 1'b0,
        BP_DIVIDED  = 1'b1
    } bp_src_e;

    typedef struct packed {
        logic ser_clk;
        logic ser_dat;
        logic sel_n;
        logic load;
        logic disp;
    } pins_t;

    // zero-based register index of a tap stage
    function automatic int tap_index(tap_e t);
        case (t)
            TAP_S30: return 29;
            TAP_S32: return 31;
            TAP_S34: return 33;
            default: return 37;
        endcase
    endfunction
endpackage

// File: rtl/lcdseg_sync.sv
module lcdseg_sync #(
    parameter int W   = 1,
    parameter int LEN = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [LEN];

    for (genvar s = 0; s < LEN; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)        chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else            chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[LEN-1];
endmodule

// File: rtl/lcdseg_shift.sv
module lcdseg_shift
    import lcdseg_pkg::*;
#(
    parameter int N = STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_clk,
    input  logic         ser_dat,
    input  logic         sel_n,
    input  logic         load,
    input  tap_e         tap,
    output logic [N-1:0] latch_q,
    output logic         casc
);
    logic [N-1:0] sr;
    logic         ser_prev;
    logic         fall, rise;

    assign fall = ser_prev & ~ser_clk;
    assign rise = ~ser_prev & ser_clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr       <= '0;
            latch_q  <= '0;
            casc     <= 1'b0;
            ser_prev <= 1'b0;
        end else begin
            ser_prev <= ser_clk;
            if (fall && !sel_n) sr <= {sr[N-2:0], ser_dat};
            if (rise)           casc <= sr[tap_index(tap)];
            if (load)           latch_q <= sr;
        end
    end

    p_shift_step_r1: assert property (@(posedge clk) disable iff (rst)
        (fall && !sel_n) |=> (sr[N-1:1] == $past(sr[N-2:0])));
    p_hold_deselected_r2: assert property (@(posedge clk) disable iff (rst)
        !(fall && !sel_n) |=> $stable(sr));
    p_latch_copy_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (latch_q == $past(sr)));
    p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(latch_q));
    p_casc_edge_r4: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(casc));
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (sr == '0 && latch_q == '0 && !casc));
endmodule

// File: rtl/lcdseg_backplane.sv
module lcdseg_backplane
    import lcdseg_pkg::*;
#(
    parameter int BITS = DIV_BITS
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    disp,
    input  bp_src_e mode,
    output logic    bp
);
    logic [BITS-1:0] cnt;
    logic            disp_prev;
    logic            disp_rise;

    assign disp_rise = disp & ~disp_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            disp_prev <= 1'b0;
        end else begin
            disp_prev <= disp;
            if (disp_rise) cnt <= cnt + 1'b1;
        end
    end

    assign bp = (mode == BP_DIVIDED) ? cnt[BITS-1] : disp;

    p_div_count_r8: assert property (@(posedge clk) disable iff (rst)
        disp_rise |=> (cnt == $past(cnt) + 1'b1));
    p_div_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !disp_rise |=> $stable(cnt));
endmodule

// File: rtl/lcdseg_core.sv
module lcdseg_core
    import lcdseg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              sel_n,
    input  logic              load,
    input  logic              disp_clk,
    input  logic              bp_mode,
    input  logic [1:0]        tap_sel,
    output logic [STAGES-1:0] seg,
    output logic              bp,
    output logic              casc_out
);
    pins_t raw, synced;
    logic [STAGES-1:0] latch_q;

    assign raw = '{ser_clk: ser_clk, ser_dat: ser_dat, sel_n: sel_n,
                   load: load, disp: disp_clk};

    lcdseg_sync #(.W($bits(pins_t)), .LEN(SYNC_LEN)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(synced)
    );

    lcdseg_shift #(.N(STAGES)) u_shift (
        .clk(clk), .rst(rst),
        .ser_clk(synced.ser_clk), .ser_dat(synced.ser_dat),
        .sel_n(synced.sel_n), .load(synced.load),
        .tap(tap_e'(tap_sel)),
        .latch_q(latch_q), .casc(casc_out)
    );

    lcdseg_backplane #(.BITS(DIV_BITS)) u_bp (
        .clk(clk), .rst(rst), .disp(synced.disp),
        .mode(bp_src_e'(bp_mode)), .bp(bp)
    );

    // segment phase: lit segments run against the backplane
    for (genvar i = 0; i < STAGES; i++) begin : g_seg
        assign seg[i] = latch_q[i] ^ bp;
    end
endmodule

// File: tb/lcdseg_core_test.sv
module lcdseg_core_test;
    localparam int CLK_NS = 10;
    localparam int N = 38;
    localparam int HALF = 8;

    logic clk = 0, rst = 1;
    logic ser_clk = 1, ser_dat = 0, sel_n = 1, load = 0, disp_clk = 0, bp_mode = 0;
    logic [1:0] tap_sel = 2'd3;
    logic [N-1:0] seg_a, seg_b;
    logic bp_a, bp_b, casc_a, casc_b;

    int applied = 0, bad = 0;
    logic [N-1:0] exp_sr = '0, exp_latch = '0;
    int dcount = 0;

    always #(CLK_NS/2) clk = ~clk;

    lcdseg_core uut (.clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .sel_n(sel_n), .load(load), .disp_clk(disp_clk), .bp_mode(bp_mode),
        .tap_sel(tap_sel), .seg(seg_a), .bp(bp_a), .casc_out(casc_a));

    lcdseg_core uut_tail (.clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(casc_a),
        .sel_n(sel_n), .load(load), .disp_clk(disp_clk), .bp_mode(bp_mode),
        .tap_sel(2'd3), .seg(seg_b), .bp(bp_b), .casc_out(casc_b));

    function automatic int tap_pos(logic [1:0] t);
        case (t) 2'd0: return 30; 2'd1: return 32; 2'd2: return 34; default: return 38; endcase
    endfunction

    function automatic logic [N-1:0] seg_model(logic [N-1:0] l, logic b);
        return l ^ {N{b}};
    endfunction

    task automatic check(input logic ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        applied++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    // one serial bit: fall shifts, rise updates cascade
    task automatic send_bit(input logic b, input logic sel);
        ser_dat = b; sel_n = sel;
        wait_clk(HALF);
        ser_clk = 0;
        wait_clk(HALF);
        ser_clk = 1;
        wait_clk(HALF);
        if (!sel) exp_sr = {exp_sr[N-2:0], b};
        if (load) exp_latch = exp_sr;
    endtask

    task automatic pulse_load();
        load = 1; wait_clk(6); load = 0; wait_clk(4);
        exp_latch = exp_sr;
    endtask

    task automatic disp_pulse();
        disp_clk = 1; wait_clk(3); disp_clk = 0; wait_clk(3);
        dcount++;
    endtask

    initial begin
        #(CLK_NS * 200000);
        bad++; applied++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        logic [N-1:0] pat, held;
        logic [75:0] stream;
        void'($urandom(32'h1cd5));
        wait_clk(4); rst = 0; wait_clk(6);

        // R9: reset state
        check(seg_a == '0 && seg_b == '0, "R9 seg reset", seg_a, '0);
        check(!casc_a && !bp_a, "R9 casc/bp reset", {36'd0, casc_a, bp_a}, '0);

        // R1/R3: random patterns, first sent bit lands on seg[37]
        for (int r = 0; r < 12; r++) begin
            pat = {$urandom, $urandom};
            if (r == 0) pat = '1;
            if (r == 1) pat = 38'h1;
            for (int k = N-1; k >= 0; k--) send_bit(pat[k], 1'b0);
            check(seg_a == held || r == 0, "R3 latch holds while load low", seg_a, held);
            pulse_load();
            check(seg_a == pat, "R1 pattern lands", seg_a, pat);
            held = pat;
        end

        // R2: deselected shifting ignored
        for (int k = 0; k < 10; k++) send_bit(~held[k], 1'b1);
        pulse_load();
        check(seg_a == held, "R2 no shift with sel_n high", seg_a, held);

        // R3: transparent latch while load high
        load = 1;
        for (int k = 0; k < 5; k++) begin
            send_bit(1'($urandom), 1'b0);
            check(seg_a == exp_sr, "R3 transparent", seg_a, exp_sr);
        end
        load = 0; wait_clk(4);

        // R4/R5: tap change alone does not move casc; next rise selects stage
        for (int t = 0; t < 4; t++) begin
            logic prev_c;
            prev_c = casc_a;
            tap_sel = 2'(t);
            wait_clk(6);
            check(casc_a == prev_c, "R4 casc stable on tap change", {37'd0, casc_a}, {37'd0, prev_c});
            send_bit(1'b0, 1'b1);
            check(casc_a == exp_sr[tap_pos(2'(t))-1], "R5 tap stage",
                  {37'd0, casc_a}, {37'd0, exp_sr[tap_pos(2'(t))-1]});
        end
        tap_sel = 2'd3;

        // R6/R7: external backplane both phases
        disp_clk = 1; dcount++; wait_clk(6);
        check(bp_a == 1'b1, "R7 bp follows high", {37'd0, bp_a}, 38'd1);
        check(seg_a == seg_model(exp_latch, 1'b1), "R6 seg antiphase", seg_a, seg_model(exp_latch, 1'b1));
        disp_clk = 0; wait_clk(6);
        check(bp_a == 1'b0, "R7 bp follows low", {37'd0, bp_a}, 38'd0);
        check(seg_a == exp_latch, "R6 seg in phase", seg_a, exp_latch);

        // R8: divided mode
        bp_mode = 1; wait_clk(4);
        while (dcount < 300) begin
            disp_pulse();
            if (dcount == 127 || dcount == 128 || dcount == 255 || dcount == 256 || dcount == 300) begin
                logic eb;
                eb = 1'((dcount >> 7) & 1);
                check(bp_a == eb, "R8 divided backplane", {37'd0, bp_a}, {37'd0, eb});
                check(seg_a == seg_model(exp_latch, eb), "R6 seg vs divided bp", seg_a, seg_model(exp_latch, eb));
            end
        end

        // R9: mid-run reset
        rst = 1; wait_clk(3); rst = 0; wait_clk(6);
        exp_sr = '0; exp_latch = '0; dcount = 0;
        check(seg_a == '0 && !bp_a && !casc_a, "R9 reset clears", seg_a, '0);
        bp_mode = 0; wait_clk(4);

        // R10: two-device chain
        stream = {$urandom, $urandom, $urandom};
        for (int k = 0; k < 76; k++) send_bit(stream[k], 1'b0);
        pulse_load();
        for (int k = 0; k < 38; k++) begin
            check(seg_b[37-k] == stream[k], "R10 tail device bit", seg_b, '0);
            check(seg_a[37-k] == stream[k+38], "R10 head device bit", seg_a, '0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule